// File: doc/BRIEF.md
# Upcounting Timer with Update Control

A 16-bit upcounting timer. A programmable prescaler divides the timer clock by its setting plus one. The counter runs from zero up to an auto-reload limit, and on the next prescaled tick it wraps back to zero and reports an overflow. An overflow, or a software-forced update, forms an update event. That event copies the buffered prescaler and reload settings into their active copies, sets a sticky interrupt flag, and can stop the counter when single-shot operation is selected. A control word can suppress update events entirely, or keep software-forced updates from raising the interrupt.

A flat word-wide register port gives access to the control word, the prescaler, the reload limit, an event/status word and the live count. Writes take effect on the clock edge at which they are presented. Reads are combinational. The block also produces a periodic enable for downstream input filters. That enable fires every 1, 2 or 4 timer clocks, as set by a two-bit divider code in the control word.

Register map (addr): 0 control, 1 prescaler, 2 reload limit, 3 event/status, 4 count (read only). Any other address reads as zero.

Top module: `upcnt_timer`

## Requirements
- R1: The control word resets to 0x0000. Its fields are: bit 0 run, bit 1 update-off, bit 2 overflow-only request, bit 3 single-shot, bit 7 buffered reload, bits 9:8 filter divider code. All other bits read as zero, so writing 0xFFFF reads back 0x038F.
- R2: With run set, the counter advances once every prescaler+1 clocks. It wraps from the active reload limit to 0, so the first overflow comes (limit+1)*(prescaler+1) clocks after run is set following a forced update.
- R3: With buffered reload clear, a write to the reload limit takes effect at once. With it set, the written value becomes active only at the next update event.
- R4: The prescaler always works from an active copy, which loads from the written value only at an update event.
- R5: With update-off set, an overflow still wraps the counter, but it produces no update event: the active reload and prescaler copies are kept, and the flag is not set.
- R6: Writing 1 to event/status bit 0 forces an update. It resets the counter and the prescaler even when update-off is set. The bit always reads back as 0.
- R7: With overflow-only request clear, both an overflow and a forced update set the interrupt flag. With it set, only an overflow does.
- R8: In single-shot mode, an update event clears the run bit in the same edge, and the counter stays stopped.
- R9: The interrupt flag (event/status bit 1) is sticky. Writing 0 to that bit clears it, and writing 1 leaves it unchanged. The interrupt output is the flag ANDed with interrupt enable (event/status bit 2).
- R10: The filter enable is high every clock for codes 00 and 11. It is high one clock in 2 for code 01, and one clock in 4 for code 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data (combinational) |
| count | output | 16 | Live counter value |
| irq | output | 1 | Update interrupt request |
| samp_en | output | 1 | Filter sampling enable |

## Verification
The hardest situation to reach is a buffered setting that is pending while the counter is running, because it only shows as a change in cadence after the next overflow. The stimulus writes new reload and prescaler values with buffering on and the counter stopped, then starts the counter. It watches the count clock by clock: the first period must use the old values, and the period after the overflow must use the new ones. The update-off case uses the same pending-write setup. The check is that the count keeps the old period over several wraps, and that a forced update still zeroes the counter.

// File: rtl/upcnt_timer.sv
module upcnt_timer #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic [W-1:0] count,
  output logic         irq,
  output logic         samp_en
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_PSC  = AW'(1);
  localparam logic [AW-1:0] A_ARR  = AW'(2);
  localparam logic [AW-1:0] A_EVT  = AW'(3);
  localparam logic [AW-1:0] A_CNT  = AW'(4);

  logic         run, updoff, ovfonly, single, buffered, flag, ien;
  logic [1:0]   div, dcnt;
  logic [W-1:0] psc_pre, psc_act, arr_pre, arr_act, pcnt, cnt;

  wire wr_ctrl  = wr_en && addr == A_CTRL;
  wire wr_psc   = wr_en && addr == A_PSC;
  wire wr_arr   = wr_en && addr == A_ARR;
  wire wr_evt   = wr_en && addr == A_EVT;
  wire force_ug = wr_evt && wdata[0];
  wire tick     = run && pcnt == psc_act;
  wire ovf      = tick && cnt >= arr_act;
  wire uev      = !updoff && (ovf || force_ug);
  wire flag_set = uev && (ovf || !ovfonly);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {run, updoff, ovfonly, single, buffered} <= '0;
      div <= '0;
    end else begin
      if (wr_ctrl) begin
        run      <= wdata[0];
        updoff   <= wdata[1];
        ovfonly  <= wdata[2];
        single   <= wdata[3];
        buffered <= wdata[7];
        div      <= wdata[9:8];
      end
      if (uev && single) run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_pre <= '0;
      psc_act <= '0;
      arr_pre <= '1;
      arr_act <= '1;
    end else begin
      if (wr_psc) psc_pre <= wdata;
      if (wr_arr) arr_pre <= wdata;
      if (uev) psc_act <= psc_pre;
      if (wr_arr && !buffered) arr_act <= wdata;
      else if (uev)            arr_act <= arr_pre;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      cnt  <= '0;
    end else if (force_ug) begin
      pcnt <= '0;
      cnt  <= '0;
    end else if (run) begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
      if (tick) cnt <= ovf ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      ien  <= 1'b0;
      dcnt <= '0;
    end else begin
      dcnt <= dcnt + 1'b1;
      if (wr_evt) ien <= wdata[2];
      if (flag_set)                 flag <= 1'b1;
      else if (wr_evt && !wdata[1]) flag <= 1'b0;
    end
  end

  assign count   = cnt;
  assign irq     = flag && ien;
  assign samp_en = (div == 2'b01) ? dcnt[0] :
                   (div == 2'b10) ? (dcnt == 2'b11) : 1'b1;

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[3:0] = {single, ovfonly, updoff, run};
        rdata[7]   = buffered;
        rdata[9:8] = div;
      end
      A_PSC:   rdata = psc_pre;
      A_ARR:   rdata = arr_pre;
      A_EVT:   rdata[2:1] = {ien, flag};
      A_CNT:   rdata = cnt;
      default: rdata = '0;
    endcase
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !force_ug |=> cnt == '0);                                  // R2
  AST_UPDOFF_KEEPS_PSC: assert property (@(posedge clk) disable iff (!rst_n)
    updoff |=> $stable(psc_act));                                     // R5
  AST_FORCE_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    force_ug |=> cnt == '0 && pcnt == '0);                            // R6
  AST_OVFONLY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ovfonly && !ovf && !flag |=> !flag);                              // R7
  AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    uev && single |=> !run);                                          // R8
  AST_DIV2_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    div == 2'b01 && samp_en && !wr_ctrl |=> !samp_en);                // R10
endmodule

// File: tb/upcnt_timer_bench.sv
module upcnt_timer_bench;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata, count;
  logic        irq, samp_en;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  upcnt_timer u_upcnt_timer (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .count(count), .irq(irq), .samp_en(samp_en));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 1000) begin @(posedge clk); #1; n++; end
  endtask

  task automatic setup(input logic [15:0] psc, input logic [15:0] arr);
    wr(0, 16'h0000); wr(1, psc); wr(2, arr); wr(3, 16'h0005); wr(3, 16'h0004);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(0, v); chk(v == 0, "R1 ctrl reset", v, 0);
    rd(3, v); chk(v == 0, "R9 status reset", v, 0);
    chk(count == 0 && irq == 0, "R1 outputs reset", {irq, count}, 0);
    wr(0, 16'hFFFF); rd(0, v); chk(v == 16'h038F, "R1 reserved bits", v, 16'h038F);
    wr(0, 16'h0000); rd(0, v); chk(v == 0, "R1 clear", v, 0);
  endtask

  task automatic t_period;
    int n;
    setup(1, 3); wr(0, 16'h0001); wait_irq(n);
    chk(n == 8, "R2 period psc1 arr3", n, 8);
    chk(count == 0, "R2 wrap", count, 0);
    setup(0, 5); wr(0, 16'h0001); wait_irq(n);
    chk(n == 6, "R2 period psc0 arr5", n, 6);
  endtask

  task automatic t_buffered;
    int n;
    setup(0, 3); wr(0, 16'h0080); wr(2, 1); wr(1, 1);
    wr(0, 16'h0081); addr = 4; wait_irq(n);
    chk(n == 4, "R3 first period old limit", n, 4);
    @(posedge clk); #1; chk(count == 0, "R4 new prescaler holds", count, 0);
    @(posedge clk); #1; chk(count == 1, "R4 new prescaler tick", count, 1);
    repeat (2) @(posedge clk); #1; chk(count == 0, "R3 new limit wrap", count, 0);
    setup(0, 3); wr(2, 2); wr(0, 16'h0001); wait_irq(n);
    chk(n == 3, "R3 immediate limit", n, 3);
  endtask

  task automatic t_updoff;
    logic [15:0] v;
    setup(0, 3); wr(0, 16'h0082); wr(2, 1); wr(0, 16'h0083);
    addr = 4; repeat (6) @(posedge clk); #1;
    chk(count == 2, "R5 old limit kept", count, 2);
    chk(irq == 0, "R5 no flag", irq, 0);
    wr(3, 16'h0005); addr = 4; #1;
    chk(count == 0, "R6 force resets under updoff", count, 0);
    chk(irq == 0, "R5 force no flag", irq, 0);
    rd(3, v); chk(v[0] == 0, "R6 force bit reads 0", v[0], 0);
    wr(0, 16'h0000);
  endtask

  task automatic t_ovfonly;
    int n;
    setup(0, 1); wr(0, 16'h0004); wr(3, 16'h0005); #1;
    chk(irq == 0, "R7 force masked", irq, 0);
    wr(0, 16'h0000); wr(3, 16'h0005); #1;
    chk(irq == 1, "R7 force raises", irq, 1);
    wr(3, 16'h0004); wr(0, 16'h0005); wait_irq(n);
    chk(n == 2, "R7 overflow raises", n, 2);
  endtask

  task automatic t_single;
    int n; logic [15:0] v;
    setup(0, 2); wr(0, 16'h0009); wait_irq(n);
    chk(n == 3, "R8 single period", n, 3);
    rd(0, v); chk(v == 16'h0008, "R8 run cleared", v, 16'h0008);
    repeat (3) @(posedge clk); #1; chk(count == 0, "R8 stays stopped", count, 0);
  endtask

  task automatic t_flag;
    logic [15:0] v;
    setup(0, 1); wr(3, 16'h0005); repeat (5) @(posedge clk); #1;
    chk(irq == 1, "R9 sticky", irq, 1);
    wr(3, 16'h0006); #1; chk(irq == 1, "R9 write 1 keeps", irq, 1);
    wr(3, 16'h0002); #1; chk(irq == 0, "R9 enable gates irq", irq, 0);
    rd(3, v); chk(v == 16'h0002, "R9 flag still set", v, 2);
    wr(3, 16'h0004); rd(3, v); chk(v == 16'h0004, "R9 cleared", v, 4);
  endtask

  task automatic t_samp(input logic [1:0] code, input int exp);
    int p = 0;
    wr(0, {6'd0, code, 8'd0});
    for (int i = 0; i < 8; i++) begin @(posedge clk); #1; if (samp_en) p++; end
    chk(p == exp, $sformatf("R10 divider code %0d", code), p, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_period; t_buffered; t_updoff; t_ovfonly; t_single; t_flag;
    t_samp(2'b00, 8); t_samp(2'b01, 4); t_samp(2'b10, 2); t_samp(2'b11, 8);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule